// File: doc/BRIEF.md
# Super-I/O Configuration Unlock Port

This block is the configuration register space of a multi-function I/O controller, reached by a host through two byte ports: an index port, which selects a register, and a data port, which reads or writes that register. The space starts out locked. Two consecutive index-port writes of the entry key open it, and one index-port write of the exit key closes it again. While the space is locked, data-port reads return all ones and data-port writes have no effect.

When the space is open, the index picks either a global register or a register in the bank of the currently selected logical device. The global registers are a logical device number, a 16-bit device identifier, a revision byte and a 16-bit vendor identifier. Both identifiers are read most significant byte first. Each logical device has an activate bit and a 16-bit I/O base address. The block drives one enable output and one base address output per device. The hardware-monitor device decodes an 8-byte window, so its base address output always has its three low bits cleared.

Reads are registered: a read strobe captures the addressed byte, and `bus_rdata` holds that byte until the next read strobe.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the space is locked, the index and the logical device number are 0x00, every `dev_en` bit is 0, every `dev_base` field is 0x0000 and `bus_rdata` is 0xFF.
- R2: The space opens only when two index-port writes (`bus_sel`=0) of 0x87 arrive with no other index-port write between them. Any other index-port value restarts the match. The write that completes the key does not change the index.
- R3: An index-port write of 0xAA while the space is open locks it without changing the index. While locked, reads of either port return 0xFF and data-port writes change nothing.
- R4: While the space is open, any other index-port write stores the byte as the index, an index-port read returns the index, and every data-port access (`bus_sel`=1) targets the register the index names. The index survives a lock and unlock cycle.
- R5: Index 0x20 reads the device identifier high byte (0x04) and 0x21 reads its low byte (0x06). Index 0x22 reads the revision (0x01). Index 0x23 reads the vendor identifier high byte (0x19) and 0x24 reads its low byte (0x34). Writes to these indices are dropped.
- R6: Index 0x07 is a read/write logical device number. It selects the bank that indices 0x30, 0x60 and 0x61 address.
- R7: Bit 0 of index 0x30 in the selected bank is that device's activate bit. It drives `dev_en[n]`, and the other seven bits read as 0. `dev_en` changes only after an open data-port write.
- R8: Indices 0x60 and 0x61 in the selected bank hold the high and low bytes of the device's base address. The base address drives bits [16n+15:16n] of `dev_base` and reads back exactly as written.
- R9: For logical device 4 (hardware monitor), bits [2:0] of its `dev_base` field are always 0. The stored value, including its low bits, still reads back unchanged.
- R10: Indices that are not implemented, and banked indices while the device number is 8 or more, read 0x00. Writes to them change no output and no register.
- R11: `bus_rdata` changes only in the cycle after a cycle with `bus_rd` high, and then shows the byte that was addressed in that cycle. If `bus_wr` is also high in that cycle, the read sees the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Byte write strobe, one cycle per write |
| bus_rd | input | 1 | Byte read strobe, one cycle per read |
| bus_sel | input | 1 | Port select: 0 index port, 1 data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| dev_en | output | NUM_LDEV | Activate bit of each logical device |
| dev_base | output | 16*NUM_LDEV | Decoded base address of each logical device |

## Verification
Four properties are checked on every cycle. The first is that `bus_rdata` holds between read strobes. The second is that a locked read returns 0xFF and that a locked state leaves the enable and base outputs untouched. The third is that every opening and closing of the space is caused, one cycle earlier, by an index write of the matching key. The fourth is that the enables only move after an open data write. Register contents, on the other hand, can only be shown by the bench's scenarios. This covers the identifier values and their byte order, the banking by device number, the silent drop of writes to read-only or absent registers, the key match restarting on a stray value, and the hardware-monitor mask against the full readback.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
    // Register indices; the host programs against these offsets.
    localparam logic [7:0] IDX_LDN      = 8'h07;
    localparam logic [7:0] IDX_DEVID_HI = 8'h20;
    localparam logic [7:0] IDX_DEVID_LO = 8'h21;
    localparam logic [7:0] IDX_REV      = 8'h22;
    localparam logic [7:0] IDX_VEND_HI  = 8'h23;
    localparam logic [7:0] IDX_VEND_LO  = 8'h24;
    localparam logic [7:0] IDX_ACT      = 8'h30;
    localparam logic [7:0] IDX_BASE_HI  = 8'h60;
    localparam logic [7:0] IDX_BASE_LO  = 8'h61;

    // Key bytes seen on the index port.
    localparam logic [7:0] KEY_OPEN     = 8'h87;
    localparam logic [7:0] KEY_CLOSE    = 8'hAA;
    localparam logic [7:0] LOCKED_BYTE  = 8'hFF;

    typedef enum logic [1:0] {
        KS_LOCKED = 2'd0,
        KS_ARMED  = 2'd1,
        KS_OPEN   = 2'd2
    } key_state_e;

    typedef struct packed {
        logic        en;
        logic [15:0] base;
    } ldev_regs_t;
endpackage

// File: rtl/sio_cfg_key.sv
// Lock state machine: two consecutive open keys unlock, one close key locks.
module sio_cfg_key
    import sio_cfg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       open
);
    key_state_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (idx_wr) begin
            unique case (state_q)
                KS_LOCKED: state_d = (wdata == KEY_OPEN) ? KS_ARMED : KS_LOCKED;
                KS_ARMED:  state_d = (wdata == KEY_OPEN) ? KS_OPEN  : KS_LOCKED;
                KS_OPEN:   state_d = (wdata == KEY_CLOSE) ? KS_LOCKED : KS_OPEN;
                default:   state_d = KS_LOCKED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KS_LOCKED;
        else        state_q <= state_d;
    end

    assign open = (state_q == KS_OPEN);
endmodule

// File: rtl/sio_cfg_ldev.sv
// Register bank of one logical device: activate bit and base address.
module sio_cfg_ldev
    import sio_cfg_pkg::*;
#(
    parameter int LOW_IGNORE = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_act,
    input  logic        wr_base_hi,
    input  logic        wr_base_lo,
    input  logic [7:0]  wdata,
    output ldev_regs_t  regs,
    output logic [15:0] base_dec
);
    ldev_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_act)     regs_d.en         = wdata[0];
        if (wr_base_hi) regs_d.base[15:8] = wdata;
        if (wr_base_lo) regs_d.base[7:0]  = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs = regs_q;

    generate
        if (LOW_IGNORE > 0) begin : g_masked
            assign base_dec = {regs_q.base[15:LOW_IGNORE], {LOW_IGNORE{1'b0}}};
        end else begin : g_full
            assign base_dec = regs_q.base;
        end
    endgenerate
endmodule

// File: rtl/sio_cfg_port.sv
// Index/data configuration port with key-gated access and per-device banks.
module sio_cfg_port
    import sio_cfg_pkg::*;
#(
    parameter int          NUM_LDEV        = 8,
    parameter int          HWM_LDEV        = 4,
    parameter int          HWM_IGNORE_BITS = 3,
    parameter logic [15:0] DEVICE_ID       = 16'h0406,
    parameter logic [7:0]  REVISION        = 8'h01,
    parameter logic [15:0] VENDOR_ID       = 16'h1934
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_wr,
    input  logic                     bus_rd,
    input  logic                     bus_sel,
    input  logic [7:0]               bus_wdata,
    output logic [7:0]               bus_rdata,
    output logic [NUM_LDEV-1:0]      dev_en,
    output logic [16*NUM_LDEV-1:0]   dev_base
);
    localparam int BASE_W = 16;

    typedef struct packed {
        logic [7:0] index;
        logic [7:0] ldn;
        logic [7:0] rdata;
    } port_state_t;

    port_state_t st_d, st_q;

    logic       cfg_open;
    logic       idx_wr;
    logic       dat_wr;
    logic [7:0] port_byte;
    logic [7:0] cfg_byte;
    ldev_regs_t cur_regs;

    logic       [NUM_LDEV-1:0] hit;
    ldev_regs_t                bank   [NUM_LDEV];
    logic [BASE_W-1:0]         decbase[NUM_LDEV];

    assign idx_wr = bus_wr & ~bus_sel;
    assign dat_wr = bus_wr & bus_sel & cfg_open;

    sio_cfg_key u_key (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx_wr (idx_wr),
        .wdata  (bus_wdata),
        .open   (cfg_open)
    );

    generate
        for (genvar i = 0; i < NUM_LDEV; i++) begin : g_ldev
            localparam int IGN = (i == HWM_LDEV) ? HWM_IGNORE_BITS : 0;

            assign hit[i] = (st_q.ldn == 8'(i));

            sio_cfg_ldev #(.LOW_IGNORE(IGN)) u_bank (
                .clk        (clk),
                .rst_n      (rst_n),
                .wr_act     (dat_wr && hit[i] && (st_q.index == IDX_ACT)),
                .wr_base_hi (dat_wr && hit[i] && (st_q.index == IDX_BASE_HI)),
                .wr_base_lo (dat_wr && hit[i] && (st_q.index == IDX_BASE_LO)),
                .wdata      (bus_wdata),
                .regs       (bank[i]),
                .base_dec   (decbase[i])
            );

            assign dev_en[i]                    = bank[i].en;
            assign dev_base[i*BASE_W +: BASE_W] = decbase[i];
        end
    endgenerate

    // Selected bank; an absent device number leaves zeros.
    always_comb begin
        cur_regs = '0;
        for (int i = 0; i < NUM_LDEV; i++) begin
            if (hit[i]) cur_regs = bank[i];
        end
    end

    always_comb begin
        unique case (st_q.index)
            IDX_LDN:      cfg_byte = st_q.ldn;
            IDX_DEVID_HI: cfg_byte = DEVICE_ID[15:8];
            IDX_DEVID_LO: cfg_byte = DEVICE_ID[7:0];
            IDX_REV:      cfg_byte = REVISION;
            IDX_VEND_HI:  cfg_byte = VENDOR_ID[15:8];
            IDX_VEND_LO:  cfg_byte = VENDOR_ID[7:0];
            IDX_ACT:      cfg_byte = {7'b0, cur_regs.en};
            IDX_BASE_HI:  cfg_byte = cur_regs.base[15:8];
            IDX_BASE_LO:  cfg_byte = cur_regs.base[7:0];
            default:      cfg_byte = 8'h00;
        endcase
    end

    always_comb begin
        if (!cfg_open)    port_byte = LOCKED_BYTE;
        else if (bus_sel) port_byte = cfg_byte;
        else              port_byte = st_q.index;
    end

    always_comb begin
        st_d = st_q;
        if (bus_rd) st_d.rdata = port_byte;
        if (idx_wr && cfg_open && (bus_wdata != KEY_CLOSE)) st_d.index = bus_wdata;
        if (dat_wr && (st_q.index == IDX_LDN)) st_d.ldn = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.index <= 8'h00;
            st_q.ldn   <= 8'h00;
            st_q.rdata <= LOCKED_BYTE;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk #(
    parameter int NUM_LDEV = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_wr,
    input logic                   bus_rd,
    input logic                   bus_sel,
    input logic [7:0]             bus_wdata,
    input logic [7:0]             bus_rdata,
    input logic [NUM_LDEV-1:0]    dev_en,
    input logic [16*NUM_LDEV-1:0] dev_base,
    input logic                   cfg_open
);
    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R3
    locked_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !cfg_open) |=> (bus_rdata == 8'hFF));

    // R3
    locked_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |=> ($stable(dev_en) && $stable(dev_base)));

    // R2
    entry_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(bus_wr && !bus_sel && (bus_wdata == 8'h87)));

    // R3
    exit_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_open) |-> $past(bus_wr && !bus_sel && (bus_wdata == 8'hAA)));

    // R7
    en_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dev_en) |-> $past(bus_wr && bus_sel && cfg_open));
endmodule

bind sio_cfg_port sio_cfg_port_chk #(.NUM_LDEV(NUM_LDEV)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_sel   (bus_sel),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .dev_en    (dev_en),
    .dev_base  (dev_base),
    .cfg_open  (cfg_open)
);

// File: tb/sio_cfg_port_test.sv
`timescale 1ns/1ps
module sio_cfg_port_test;
    localparam int N = 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_wr = 1'b0;
    logic           bus_rd = 1'b0;
    logic           bus_sel = 1'b0;
    logic [7:0]     bus_wdata = 8'h00;
    logic [7:0]     bus_rdata;
    logic [N-1:0]   dev_en;
    logic [16*N-1:0] dev_base;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    sio_cfg_port uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_sel(bus_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dev_en(dev_en), .dev_base(dev_base)
    );

    // Reference model built from the requirements.
    bit          m_open, m_armed;
    logic [7:0]  m_idx, m_ldn;
    logic        m_en  [N];
    logic [15:0] m_base[N];

    function automatic logic [7:0] model_read(bit sel);
        if (!m_open) return 8'hFF;
        if (!sel) return m_idx;
        case (m_idx)
            8'h07: return m_ldn;
            8'h20: return 8'h04;
            8'h21: return 8'h06;
            8'h22: return 8'h01;
            8'h23: return 8'h19;
            8'h24: return 8'h34;
            8'h30: return (m_ldn < N) ? {7'b0, m_en[m_ldn[2:0]]} : 8'h00;
            8'h60: return (m_ldn < N) ? m_base[m_ldn[2:0]][15:8] : 8'h00;
            8'h61: return (m_ldn < N) ? m_base[m_ldn[2:0]][7:0] : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    function automatic void model_write(bit sel, logic [7:0] d);
        if (!sel) begin
            if (!m_open) begin
                if (d == 8'h87) begin
                    if (m_armed) begin m_open = 1; m_armed = 0; end
                    else m_armed = 1;
                end else m_armed = 0;
            end else if (d == 8'hAA) m_open = 0;
            else m_idx = d;
        end else if (m_open) begin
            case (m_idx)
                8'h07: m_ldn = d;
                8'h30: if (m_ldn < N) m_en[m_ldn[2:0]] = d[0];
                8'h60: if (m_ldn < N) m_base[m_ldn[2:0]][15:8] = d;
                8'h61: if (m_ldn < N) m_base[m_ldn[2:0]][7:0] = d;
                default: ;
            endcase
        end
    endfunction

    function automatic logic [127:0] exp_base();
        logic [127:0] v;
        for (int i = 0; i < N; i++)
            v[i*16 +: 16] = (i == 4) ? {m_base[i][15:3], 3'b000} : m_base[i];
        return v;
    endfunction

    function automatic logic [7:0] exp_en();
        logic [7:0] v;
        for (int i = 0; i < N; i++) v[i] = m_en[i];
        return v;
    endfunction

    task automatic check(string req, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(bit sel, logic [7:0] d);
        @(negedge clk);
        bus_wr = 1; bus_sel = sel; bus_wdata = d;
        model_write(sel, d);
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(bit sel, string req);
        logic [7:0] e;
        @(negedge clk);
        e = model_read(sel);
        bus_rd = 1; bus_sel = sel;
        @(negedge clk);
        bus_rd = 0;
        check(req, {120'b0, bus_rdata}, {120'b0, e});
    endtask

    task automatic chk_out(string req);
        check(req, {120'b0, dev_en}, {120'b0, exp_en()});
        check(req, dev_base, exp_base());
    endtask

    task automatic unlock();
        wr(0, 8'h87); wr(0, 8'h87);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] held;
        logic [7:0] cand[12];
        m_open = 0; m_armed = 0; m_idx = 0; m_ldn = 0;
        for (int i = 0; i < N; i++) begin m_en[i] = 0; m_base[i] = 0; end
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check("R1 rdata", {120'b0, bus_rdata}, 128'hFF);
        chk_out("R1 outputs");
        rd(1, "R1 locked data read");
        rd(0, "R3 locked index read");

        // R2 interrupted key does not open
        wr(0, 8'h87); wr(0, 8'h12); wr(0, 8'h87);
        rd(1, "R2 interrupted key");
        wr(0, 8'h87);
        rd(0, "R2 opened, index unchanged by key");

        // R5 identification bytes and read-only behaviour
        for (int k = 8'h20; k <= 8'h24; k++) begin
            wr(0, 8'(k));
            rd(1, "R5 id byte");
        end
        wr(0, 8'h20); wr(1, 8'h55);
        rd(1, "R5 write dropped");

        // R6 R7 R8 device 2
        wr(0, 8'h07); wr(1, 8'h02); rd(1, "R6 ldn readback");
        wr(0, 8'h30); wr(1, 8'hFF); rd(1, "R7 activate reads bit0 only");
        chk_out("R7 dev_en");
        wr(0, 8'h60); wr(1, 8'h12); wr(0, 8'h61); wr(1, 8'h3F);
        rd(1, "R8 base lo readback");
        wr(0, 8'h60); rd(1, "R8 base hi readback");
        chk_out("R8 dev_base");

        // R9 hardware-monitor mask
        wr(0, 8'h07); wr(1, 8'h04);
        wr(0, 8'h60); wr(1, 8'hAB); wr(0, 8'h61); wr(1, 8'hCF);
        rd(1, "R9 stored low bits kept");
        chk_out("R9 masked output");
        check("R9 hwm base", {112'b0, dev_base[4*16 +: 16]}, 128'hABC8);

        // R10 absent device and unimplemented index
        wr(0, 8'h07); wr(1, 8'h09);
        wr(0, 8'h30); wr(1, 8'h01); rd(1, "R10 absent bank act");
        chk_out("R10 no output change");
        wr(0, 8'h50); wr(1, 8'h77); rd(1, "R10 unimplemented index");

        // R3 lock and dropped writes
        wr(0, 8'h07); wr(1, 8'h02); wr(0, 8'h30);
        wr(0, 8'hAA);
        wr(1, 8'h00);
        chk_out("R3 locked write ignored");
        rd(1, "R3 locked data read");

        // R4 index survives lock, data targets last index
        unlock();
        rd(0, "R4 index retained");
        rd(1, "R4 data targets index");

        // R11 hold between reads, read-before-write ordering
        held = bus_rdata;
        wr(1, 8'h00);
        repeat (3) @(negedge clk);
        check("R11 rdata held", {120'b0, bus_rdata}, {120'b0, held});
        @(negedge clk);
        held = model_read(1);
        bus_rd = 1; bus_wr = 1; bus_sel = 1; bus_wdata = 8'h01;
        model_write(1, 8'h01);
        @(negedge clk);
        bus_rd = 0; bus_wr = 0;
        check("R11 read sees pre-write value", {120'b0, bus_rdata}, {120'b0, held});
        chk_out("R7 write took effect");

        // Random traffic
        cand = '{8'h07, 8'h20, 8'h23, 8'h24, 8'h30, 8'h60, 8'h61, 8'h87, 8'h87, 8'hAA, 8'h22, 8'h41};
        for (int n = 0; n < 3000; n++) begin
            int op;
            op = $urandom_range(0, 9);
            if (op < 3) wr(0, cand[$urandom_range(0, 11)]);
            else if (op < 5) begin
                if (m_idx == 8'h07) wr(1, 8'($urandom_range(0, 9)));
                else wr(1, 8'($urandom));
            end else if (op < 8) rd(1, "R4 random data read");
            else if (op < 9) rd(0, "R4 random index read");
            else chk_out("R8 random outputs");
        end

        finish_run();
    end
endmodule